// File: doc/BRIEF.md
# 8-bit compare-match timer with selectable counter clear

This block is an 8-bit up-counter that advances by one on each cycle in which a count-enable strobe is high. Two compare registers, A and B, are checked against the counter on every count event, and a status register records compare matches and counter wrap-around. A 2-bit clear-select field picks what returns the counter to zero. The choices are nothing, a match on A, a match on B, or an external reset pin. The pin can act on its rising edge or as a level.

Software reaches all state through a small register port. Reads return data combinationally. Writes take effect at the clock edge. Each status flag has its own enable bit, and the flag and its enable together drive a dedicated interrupt request output. Clock prescaling and output waveform generation are handled outside this block.

Register map (`reg_addr`): 0 = CTRL, 1 = STAT, 2 = CNT, 3 = CMPA, 4 = CMPB. Any other address reads as 0x00.

Top module: `tmr8_cmpclr`

## Requirements
- R1: After reset, CTRL, STAT and CNT read 0x00, CMPA and CMPB read 0xFF, and all three interrupt outputs are low.
- R2: CNT increments by one, wrapping from 0xFF to 0x00, only at clock edges where `cnt_en` is high. It holds its value otherwise.
- R3: On a count event with CNT = 0xFF that is not turned into a compare clear, STAT bit 2 (overflow) sets. A compare-match clear never sets it.
- R4: A count event with CNT equal to CMPA sets STAT bit 0. A count event with CNT equal to CMPB sets STAT bit 1.
- R5: CTRL[4:3] selects the clear source. 00 never clears. 01 makes a count event that matches CMPA load 0 instead of incrementing. 10 does the same for CMPB.
- R6: With CTRL[4:3] = 11 and CTRL[5] = 0, a rising edge on `ext_clr_in` clears CNT once. The pin passes through a two-flop synchronizer, so CNT reads 0 from the third clock edge after the edge. Holding the pin high does not stop counting afterwards.
- R7: With CTRL[4:3] = 11 and CTRL[5] = 1, CNT is held at 0 while the synchronized `ext_clr_in` is high, and count events have no effect.
- R8: A STAT flag clears only when 0 is written to its bit after STAT was read with that bit at 1. Writing 0 without a prior read leaves the flag set. If the flag's set condition occurs in the same cycle as the clearing write, the flag stays set.
- R9: `irq_cma`, `irq_cmb` and `irq_ovf` are high exactly when STAT bits 0, 1 and 2 are set and the matching enables CTRL bits 0, 1 and 2 are set.
- R10: A register-port write to CNT loads the written value, even if a count event or a clear happens in the same cycle.
- R11: Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms flag clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| cnt_en | input | 1 | Count-enable strobe |
| ext_clr_in | input | 1 | External counter-clear pin (asynchronous) |
| irq_cma | output | 1 | Compare-A interrupt request |
| irq_cmb | output | 1 | Compare-B interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The counter is run through each of the four clear-select settings with the same kind of strobe sequence. A run under setting 00 passes a compare value without stopping. This separates "no clearing" from clearing on A or on B. Under setting 10, the counter passes a lower CMPA match before it is cleared at CMPB, which shows that only the selected comparator clears it. The external pin is tried held high in both edge and level mode: edge mode must resume counting, while level mode must stay at zero. Wrap-around is tried both with and without a coinciding compare clear. This tells a true overflow apart from a clear. Flag clearing is tried with a read beforehand, without one, and with a clear that collides with a set.

// File: rtl/tmr8_cmpclr.sv
module tmr8_cmpclr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [2:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         cnt_en,
  input  logic         ext_clr_in,
  output logic         irq_cma,
  output logic         irq_cmb,
  output logic         irq_ovf
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CNT = 3'd2,
                         A_CMPA = 3'd3, A_CMPB = 3'd4;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [5:0]   ctrl;
  logic [2:0]   flg, armed;
  logic [W-1:0] cnt, cmpa, cmpb;
  logic         s1, s2, s3;

  wire [1:0] clr_sel  = ctrl[4:3];
  wire       ext_lvl  = ctrl[5];
  wire       wr_cnt   = reg_wr && reg_addr == A_CNT;
  wire       wr_stat  = reg_wr && reg_addr == A_STAT;
  wire       rd_stat  = reg_rd && reg_addr == A_STAT;
  wire       ext_rise = s2 && !s3;
  wire       ext_clr  = clr_sel == 2'b11 && (ext_lvl ? s2 : ext_rise);
  wire       step     = cnt_en && !wr_cnt && !ext_clr;
  wire       hit_a    = step && cnt == cmpa;
  wire       hit_b    = step && cnt == cmpb;
  wire       mclr     = (clr_sel == 2'b01 && hit_a) || (clr_sel == 2'b10 && hit_b);
  wire       wrap     = step && cnt == MAXV && !mclr;
  wire [2:0] set_v    = {wrap, hit_b, hit_a};
  wire [2:0] clr_v    = {3{wr_stat}} & ~reg_wdata[2:0] & armed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {ext_clr_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      cmpa <= MAXV;
      cmpb <= MAXV;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) ctrl <= reg_wdata[5:0];
      if (reg_addr == A_CMPA) cmpa <= reg_wdata;
      if (reg_addr == A_CMPB) cmpb <= reg_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (wr_cnt)           cnt <= reg_wdata;
    else if (ext_clr || mclr)  cnt <= '0;
    else if (step)             cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg   <= '0;
      armed <= '0;
    end else begin
      flg   <= set_v | (flg & ~clr_v);
      armed <= (armed | ({3{rd_stat}} & flg)) & ~({3{wr_stat}} & ~reg_wdata[2:0]);
    end

  always_comb
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(W-6){1'b0}}, ctrl};
      A_STAT:  reg_rdata = {{(W-3){1'b0}}, flg};
      A_CNT:   reg_rdata = cnt;
      A_CMPA:  reg_rdata = cmpa;
      A_CMPB:  reg_rdata = cmpb;
      default: reg_rdata = '0;
    endcase

  assign irq_cma = flg[0] & ctrl[0];
  assign irq_cmb = flg[1] & ctrl[1];
  assign irq_ovf = flg[2] & ctrl[2];

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt && !ext_clr) |=> $stable(cnt));
  p_ovf_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == MAXV && !mclr) |=> flg[2]);
  p_no_ovf_on_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr && !flg[2]) |=> !flg[2]);
  p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flg[1]);
  p_match_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr && !wr_cnt) |=> cnt == '0);
  p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 2'b11 && ext_lvl && s2 && !wr_cnt) |=> cnt == '0);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flg[0]);
  p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(reg_wdata));
endmodule

// File: tb/tb_tmr8_cmpclr.sv
`timescale 1ns/1ps
module tb_tmr8_cmpclr;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, cnt_en = 0, ext_clr_in = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, v;
  logic irq_cma, irq_cmb, irq_ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr8_cmpclr dut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
                   .cnt_en, .ext_clr_in, .irq_cma, .irq_cmb, .irq_ovf);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1;
      @(negedge clk); cnt_en = 0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_flags();
    rd(1, v); wr(1, 8'h00);
  endtask

  task automatic t_reset();
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 stat", v, 8'h00);
    rd(2, v); chk("R1 cnt", v, 8'h00);
    rd(3, v); chk("R1 cmpa", v, 8'hFF);
    rd(4, v); chk("R1 cmpb", v, 8'hFF);
    chk("R1 irqs", {5'b0, irq_ovf, irq_cmb, irq_cma}, 8'h00);
    rd(5, v); chk("R11 unmapped", v, 8'h00);
  endtask

  task automatic t_count();
    wr(2, 8'h00); tick(5); idle(6);
    rd(2, v); chk("R2 count only on strobe", v, 8'h05);
  endtask

  task automatic t_overflow_and_flags();
    wr(0, 8'h00); wr(2, 8'hFE); tick(2);
    rd(2, v); chk("R2 wrap", v, 8'h00);
    rd(1, v); chk("R3 R4 flags on wrap", v, 8'h07);
    wr(1, 8'h00);
    rd(1, v); chk("R8 clear after read", v, 8'h00);
    wr(2, 8'hFF); tick(1);
    wr(1, 8'h00);
    rd(1, v); chk("R8 write without read ignored", v, 8'h07);
    wr(1, 8'h00);
    rd(1, v); chk("R8 clear after read 2", v, 8'h00);
  endtask

  task automatic t_set_wins();
    wr(3, 8'h05); wr(2, 8'h05); tick(1);
    rd(1, v); chk("R4 match A", v, 8'h01);
    wr(2, 8'h05);
    @(negedge clk); cnt_en = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 8'h00;
    @(negedge clk); cnt_en = 0; reg_wr = 0;
    rd(1, v); chk("R8 set wins over clear", v, 8'h01);
    clr_flags();
  endtask

  task automatic t_clear_a();
    wr(3, 8'h03); wr(0, 8'h08); wr(2, 8'h00); tick(3);
    rd(2, v); chk("R5 up to match A", v, 8'h03);
    tick(1);
    rd(2, v); chk("R5 clear on A", v, 8'h00);
    rd(1, v); chk("R4 A flag on clear", v, 8'h01);
    wr(1, 8'h00);
    wr(3, 8'hFF); wr(2, 8'hFE); tick(2);
    rd(2, v); chk("R5 clear at FF", v, 8'h00);
    rd(1, v); chk("R3 no ovf on compare clear", v, 8'h03);
    wr(1, 8'h00);
  endtask

  task automatic t_clear_b();
    wr(3, 8'h02); wr(4, 8'h05); wr(0, 8'h10); wr(2, 8'h00); tick(3);
    rd(2, v); chk("R5 A does not clear in mode 10", v, 8'h03);
    tick(3);
    rd(2, v); chk("R5 clear on B", v, 8'h00);
    rd(1, v); chk("R4 A and B flags", v, 8'h03);
    wr(1, 8'h00);
  endtask

  task automatic t_no_clear();
    wr(0, 8'h00); wr(3, 8'h02); wr(4, 8'hFF); wr(2, 8'h00); tick(4);
    rd(2, v); chk("R5 mode 00 never clears", v, 8'h04);
    clr_flags();
  endtask

  task automatic t_ext_edge();
    wr(0, 8'h18); wr(2, 8'h40);
    @(negedge clk); ext_clr_in = 1;
    idle(4);
    rd(2, v); chk("R6 edge clears", v, 8'h00);
    tick(3);
    rd(2, v); chk("R6 held high keeps counting", v, 8'h03);
    ext_clr_in = 0; idle(4); ext_clr_in = 1; idle(4);
    rd(2, v); chk("R6 second edge clears", v, 8'h00);
  endtask

  task automatic t_ext_level();
    wr(0, 8'h38); wr(2, 8'h20); idle(2); tick(3);
    rd(2, v); chk("R7 held at zero", v, 8'h00);
    ext_clr_in = 0; idle(4); tick(2);
    rd(2, v); chk("R7 counts after release", v, 8'h02);
  endtask

  task automatic t_irq();
    wr(0, 8'h00); clr_flags();
    wr(3, 8'h10); wr(2, 8'h10); tick(1);
    chk("R9 cma masked", {7'b0, irq_cma}, 8'h00);
    wr(0, 8'h01);
    chk("R9 cma passed", {7'b0, irq_cma}, 8'h01);
    wr(2, 8'hFF); tick(1);
    chk("R9 ovf masked", {7'b0, irq_ovf}, 8'h00);
    wr(0, 8'h05);
    chk("R9 ovf passed", {7'b0, irq_ovf}, 8'h01);
    chk("R9 cmb masked", {7'b0, irq_cmb}, 8'h00);
    wr(0, 8'h02);
    chk("R9 only cmb", {5'b0, irq_ovf, irq_cmb, irq_cma}, 8'h02);
  endtask

  task automatic t_wr_priority();
    wr(0, 8'h08); wr(3, 8'h03); wr(2, 8'h03);
    @(negedge clk); cnt_en = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 8'h80;
    @(negedge clk); cnt_en = 0; reg_wr = 0;
    rd(2, v); chk("R10 write beats count and clear", v, 8'h80);
  endtask

  initial begin
    idle(3); rst_n = 1; idle(2);
    t_reset();
    t_count();
    t_overflow_and_flags();
    t_set_wins();
    t_clear_a();
    t_clear_b();
    t_no_clear();
    t_ext_edge();
    t_ext_level();
    t_irq();
    t_wr_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule